// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block produces the negative, zero, overflow and carry flags of the most recent ALU operation from operands that the datapath recorded earlier. It does not compute the operation itself. It is given the operation class, the operand width, the source, destination and result words, and the upper word of a multiply. It is also given a per-flag update mask and the current extended-arithmetic state. From these it derives a flag set and merges it into a registered status word.

The flag logic is combinational. The status word changes only on the clock edge where the evaluate strobe is high, so a pipeline can delay flag resolution until an instruction actually reads the flags. Several operation classes have their own rules:

- Subtract and compare invert the source and flip the carry.
- The multiply-carry-propagate class reports its carry in a separate R flag.
- The two multiply classes look at a 64-bit product.
- Bit test writes N and Z directly, without using the mask.

Top module: `ccflag_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sr_o` becomes 0.
- R2: `sr_o` changes only on the edge after a cycle with `eval_i` high. Otherwise it holds its value whatever the other inputs do.
- R3: `size_i` selects the width: 0 means byte (sign bit 7, Z tests `res[7:0]`), 1 means half-word (sign bit 15, Z tests `res[15:0]`), and 2 or 3 means word (sign bit 31, Z tests all 32 bits). Status bit positions are C=0, V=1, Z=2, N=3, X=4, R=8.
- R4: Add (`op_i`=0), when the result sign is 1: N=1, V is set when both operand signs are 0, and C is set when both are 1. When the result sign is 0: Z is set if the result is zero, V is set when both signs are 1, and C is set when either sign is 1.
- R5: Subtract/compare (`op_i`=1) applies the R4 rules with the source sign inverted, then inverts C.
- R6: Move/logic/shift (`op_i`=2) derives only N and Z from the result. V, C and R are written 0 where the mask selects them.
- R7: Multiply-carry-propagate (`op_i`=3) follows the add rules but puts the carry condition in R (bit 8). C is written 0.
- R8: Signed multiply (`op_i`=4) treats {`mulhi_i`,`res_i`} as a 64-bit value. Z is set when it is zero and N when it is negative. V is set when `mulhi_i` is not the sign extension of `res_i`.
- R9: Unsigned multiply (`op_i`=5) takes Z from the 64-bit value being zero, N from bit 63, and V from `mulhi_i` being nonzero.
- R10: Bit test (`op_i`=6) ignores the mask. N becomes bit `src_i[4:0]` of `dst_i`. Z is set when that bit and all lower bits are zero. X is cleared. V and C are cleared when `CORE_REV` < 32 (the default is 10). All other bits are kept.
- R11: For classes 0–5, only bits set in `upd_mask_i`, plus X, are replaced. X always becomes 0.
- R12: For classes 0–5, when `x_i` is 1 and the computed Z is 1, Z keeps its previous value.
- R13: Class 7 leaves `sr_o` unchanged even when `eval_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe; status is updated on the next edge |
| op_i | input | 3 | Operation class code |
| size_i | input | 2 | Operand width code |
| src_i | input | 32 | Recorded source operand (bit index for bit test) |
| dst_i | input | 32 | Recorded destination operand |
| res_i | input | 32 | Recorded result |
| mulhi_i | input | 32 | Upper word of the multiply product |
| upd_mask_i | input | 16 | Flags that the operation may update |
| x_i | input | 1 | Extended-arithmetic state before the operation |
| sr_o | output | 16 | Registered status word |

## Verification
On every cycle the assertions check the following:
- The status holds when no evaluation is requested, and on class 7.
- X is cleared after every evaluation.
- Z never rises under extended arithmetic.
- An unmasked carry is left alone.
- Bit test clears V and C at the default core revision.

The exact flag values need the bench's directed scenarios. These cover the sign and overflow patterns for each width, the subtract inversion, the R-flag routing of the carry-propagate class, the signed and unsigned product rules, and the bit-test lower-bits rule. Only these scenarios show that partial masks leave the unselected flags in place.

// File: rtl/ccflag_pkg.sv
// Package: shared opcode encoding, status bit positions and flag bundle.
// Assumes the status word is at least 9 bits wide (R flag at bit 8).
package ccflag_pkg;
    typedef enum logic [2:0] {
        OPC_ADD  = 3'd0,
        OPC_SUB  = 3'd1,
        OPC_MOVE = 3'd2,
        OPC_MCP  = 3'd3,
        OPC_MULS = 3'd4,
        OPC_MULU = 3'd5,
        OPC_BTST = 3'd6,
        OPC_HOLD = 3'd7
    } opc_e;

    localparam int FB_C = 0;
    localparam int FB_V = 1;
    localparam int FB_Z = 2;
    localparam int FB_N = 3;
    localparam int FB_X = 4;
    localparam int FB_R = 8;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic r;
    } flags_t;
endpackage

// File: rtl/ccflag_arith.sv
// Module: flag derivation for add, subtract/compare, move/logic/shift and
// carry-propagate classes. Purely combinational. Assumes DW >= 16.
module ccflag_arith
    import ccflag_pkg::*;
#(
    parameter int DW = 32
) (
    input  opc_e          op_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] res_i,
    output flags_t        flags_o
);
    int   sbit;
    logic zero_w;
    logic s_src, s_dst, s_res, cy, inv;

    // Pick the sign bit and the zero test for the operand width.
    always_comb begin
        case (size_i)
            2'd0: begin sbit = 7;      zero_w = (res_i[7:0]  == '0); end
            2'd1: begin sbit = 15;     zero_w = (res_i[15:0] == '0); end
            default: begin sbit = DW-1; zero_w = (res_i == '0); end
        endcase
    end

    // Apply the sign-pattern rules and route carry to C or R by class.
    always_comb begin
        inv   = (op_i == OPC_SUB);
        s_src = src_i[sbit] ^ inv;
        s_dst = dst_i[sbit];
        s_res = res_i[sbit];
        flags_o = '0;
        cy    = 1'b0;
        if (op_i == OPC_MOVE) begin
            flags_o.n = s_res;
            flags_o.z = !s_res && zero_w;
        end else begin
            if (s_res) begin
                flags_o.n = 1'b1;
                flags_o.v = !s_src && !s_dst;
                cy        = s_src && s_dst;
            end else begin
                flags_o.z = zero_w;
                flags_o.v = s_src && s_dst;
                cy        = s_src || s_dst;
            end
            if (op_i == OPC_MCP) flags_o.r = cy;
            else                 flags_o.c = cy ^ inv;
        end
    end
endmodule

// File: rtl/ccflag_mul.sv
// Module: flag derivation for a double-width multiply product.
// Combinational; signed_i selects the signed overflow rule.
module ccflag_mul
    import ccflag_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          signed_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    output flags_t        flags_o
);
    // Zero and sign of the full product; overflow by signedness.
    always_comb begin
        flags_o   = '0;
        flags_o.z = (hi_i == '0) && (lo_i == '0);
        flags_o.n = hi_i[DW-1];
        flags_o.v = signed_i ? (hi_i != {DW{lo_i[DW-1]}}) : (hi_i != '0);
    end
endmodule

// File: rtl/ccflag_btst.sv
// Module: bit-test flags. N is the selected bit; Z is set when the selected
// bit and everything below it are zero. Combinational.
module ccflag_btst #(
    parameter int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] val_i,
    output logic          n_o,
    output logic          z_o
);
    logic [DW-1:0] low_mask;

    // Build a mask covering bits idx..0 and test them.
    always_comb begin
        low_mask = {DW{1'b1}} >> ((DW-1) - int'(idx_i));
        n_o      = val_i[idx_i];
        z_o      = ((val_i & low_mask) == '0);
    end
endmodule

// File: rtl/ccflag_merge.sv
// Module: merges a computed flag set into the status word. Masked update
// for normal classes, fixed clear/set for bit test, passthrough for hold.
module ccflag_merge
    import ccflag_pkg::*;
#(
    parameter int SR_W     = 16,
    parameter int CORE_REV = 10
) (
    input  opc_e            op_i,
    input  logic [SR_W-1:0] sr_i,
    input  flags_t          flags_i,
    input  logic            bt_n_i,
    input  logic            bt_z_i,
    input  logic [SR_W-1:0] mask_i,
    input  logic            x_i,
    output logic [SR_W-1:0] sr_o
);
    localparam logic [SR_W-1:0] ONE     = {{(SR_W-1){1'b0}}, 1'b1};
    localparam logic [SR_W-1:0] BT_BASE = (ONE << FB_X) | (ONE << FB_N) | (ONE << FB_Z);
    localparam logic [SR_W-1:0] BT_VC   = (CORE_REV < 32) ? ((ONE << FB_V) | (ONE << FB_C)) : '0;
    localparam logic [SR_W-1:0] BT_CLR  = BT_BASE | BT_VC;

    logic [SR_W-1:0] fv, m, bt_w;

    // Place flags in the word and build the effective write mask.
    always_comb begin
        fv        = '0;
        fv[FB_N]  = flags_i.n;
        fv[FB_Z]  = flags_i.z;
        fv[FB_V]  = flags_i.v;
        fv[FB_C]  = flags_i.c;
        fv[FB_R]  = flags_i.r;
        m         = mask_i | (ONE << FB_X);
        if (x_i && flags_i.z) m[FB_Z] = 1'b0;
        bt_w       = sr_i & ~BT_CLR;
        bt_w[FB_N] = bt_n_i;
        bt_w[FB_Z] = bt_z_i;
    end

    // Select the next status word by class.
    always_comb begin
        case (op_i)
            OPC_HOLD: sr_o = sr_i;
            OPC_BTST: sr_o = bt_w;
            default:  sr_o = (sr_i & ~m) | (fv & m);
        endcase
    end
endmodule

// File: rtl/ccflag_unit.sv
// Module: top of the deferred flag evaluator. Chooses the flag source by
// class, merges it and registers the status on the evaluate strobe.
// Synchronous active-low reset clears the status.
module ccflag_unit
    import ccflag_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SR_W     = 16,
    parameter int CORE_REV = 10,
    localparam int IW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval_i,
    input  logic [2:0]      op_i,
    input  logic [1:0]      size_i,
    input  logic [DW-1:0]   src_i,
    input  logic [DW-1:0]   dst_i,
    input  logic [DW-1:0]   res_i,
    input  logic [DW-1:0]   mulhi_i,
    input  logic [SR_W-1:0] upd_mask_i,
    input  logic            x_i,
    output logic [SR_W-1:0] sr_o
);
    opc_e            opc;
    flags_t          f_arith, f_mul, f_sel;
    logic            bt_n, bt_z;
    logic [SR_W-1:0] sr_q, sr_next;

    assign opc = opc_e'(op_i);

    ccflag_arith #(.DW(DW)) u_arith (
        .op_i(opc), .size_i(size_i), .src_i(src_i), .dst_i(dst_i),
        .res_i(res_i), .flags_o(f_arith)
    );

    ccflag_mul #(.DW(DW)) u_mul (
        .signed_i(opc == OPC_MULS), .hi_i(mulhi_i), .lo_i(res_i),
        .flags_o(f_mul)
    );

    ccflag_btst #(.DW(DW)) u_btst (
        .idx_i(src_i[IW-1:0]), .val_i(dst_i), .n_o(bt_n), .z_o(bt_z)
    );

    // Choose the multiply or arithmetic flag set.
    always_comb f_sel = (opc == OPC_MULS || opc == OPC_MULU) ? f_mul : f_arith;

    ccflag_merge #(.SR_W(SR_W), .CORE_REV(CORE_REV)) u_merge (
        .op_i(opc), .sr_i(sr_q), .flags_i(f_sel), .bt_n_i(bt_n),
        .bt_z_i(bt_z), .mask_i(upd_mask_i), .x_i(x_i), .sr_o(sr_next)
    );

    // Status register: cleared on reset, loaded on the evaluate strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_q <= '0;
        else if (eval_i) sr_q <= sr_next;
    end

    assign sr_o = sr_q;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(sr_o));

    p_hold_class_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && op_i == 3'd7) |=> $stable(sr_o));

    p_x_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && op_i != 3'd7) |=> !sr_o[FB_X]);

    p_carry_unmasked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && op_i < 3'd6 && !upd_mask_i[FB_C]) |=> (sr_o[FB_C] == $past(sr_o[FB_C])));

    p_z_no_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && x_i && op_i < 3'd6) |=> !(sr_o[FB_Z] && !$past(sr_o[FB_Z])));

    generate
        if (CORE_REV < 32) begin : g_old_rev
            p_btst_vc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (eval_i && op_i == 3'd6) |=> (!sr_o[FB_V] && !sr_o[FB_C]));
        end
    endgenerate
endmodule

// File: tb/ccflag_unit_test.sv
module ccflag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] src_i = '0, dst_i = '0, res_i = '0, mulhi_i = '0;
    logic [15:0] upd_mask_i = '0;
    logic        x_i = 1'b0;
    logic [15:0] sr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [15:0] MFULL = 16'h010F;

    ccflag_unit uut (.*);

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [15:0] exp);
        n_chk++;
        if (sr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: sr_o=%h expected=%h", tag, sr_o, exp);
        end
    endtask

    // One evaluate pulse; returns after the status has been registered.
    task automatic fire(logic [2:0] op, logic [1:0] sz, logic [31:0] s, logic [31:0] d,
                        logic [31:0] r, logic [31:0] h, logic [15:0] m, logic x);
        @(negedge clk);
        op_i = op; size_i = sz; src_i = s; dst_i = d; res_i = r;
        mulhi_i = h; upd_mask_i = m; x_i = x; eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        chk("R1 reset", 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        fire(3'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, MFULL, 0);
        chk("R4 add overflow", 16'h000A);
        fire(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, MFULL, 0);
        chk("R4 add carry zero", 16'h0005);
        fire(3'd0, 2'd0, 32'h80, 32'h80, 32'h100, 0, MFULL, 0);
        chk("R3 byte width", 16'h0007);
        fire(3'd0, 2'd1, 32'h7000, 32'h1000, 32'h1_8000, 0, MFULL, 0);
        chk("R3 half width", 16'h000A);
    endtask

    task automatic t_sub;
        fire(3'd1, 2'd2, 32'd3, 32'd5, 32'd2, 0, MFULL, 0);
        chk("R5 sub no borrow", 16'h0000);
        fire(3'd1, 2'd2, 32'd5, 32'd3, 32'hFFFF_FFFE, 0, MFULL, 0);
        chk("R5 sub borrow", 16'h0009);
        fire(3'd1, 2'd2, 32'd5, 32'd5, 32'd0, 0, MFULL, 0);
        chk("R5 sub equal", 16'h0004);
    endtask

    task automatic t_move;
        fire(3'd0, 2'd0, 32'h80, 32'h80, 32'h100, 0, MFULL, 0);
        fire(3'd2, 2'd1, 32'h0, 32'h0, 32'h1_8000, 0, MFULL, 0);
        chk("R6 move half neg", 16'h0008);
        fire(3'd2, 2'd1, 32'hFFFF, 32'hFFFF, 32'h1234_0000, 0, MFULL, 0);
        chk("R6 move half zero", 16'h0004);
    endtask

    task automatic t_mask_x;
        fire(3'd2, 2'd2, 0, 0, 32'h8000_0000, 0, MFULL, 0);
        fire(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 16'h0001, 0);
        chk("R11 partial mask", 16'h0009);
        fire(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, MFULL, 1);
        chk("R12 z kept clear", 16'h0001);
        fire(3'd0, 2'd2, 0, 0, 0, 0, MFULL, 0);
        fire(3'd0, 2'd2, 32'h1, 32'h1, 32'h2, 0, MFULL, 1);
        chk("R12 z may clear", 16'h0000);
    endtask

    task automatic t_mcp;
        fire(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h2, 32'h1, 0, MFULL, 0);
        fire(3'd3, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, MFULL, 0);
        chk("R7 mcp carry in R", 16'h0104);
    endtask

    task automatic t_mul;
        fire(3'd4, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, MFULL, 0);
        chk("R8 muls negative", 16'h0008);
        fire(3'd4, 2'd2, 0, 0, 32'h8000_0000, 32'h0, MFULL, 0);
        chk("R8 muls overflow", 16'h0002);
        fire(3'd4, 2'd2, 0, 0, 32'h0, 32'h0, MFULL, 0);
        chk("R8 muls zero", 16'h0004);
        fire(3'd5, 2'd2, 0, 0, 32'h0, 32'h1, MFULL, 0);
        chk("R9 mulu overflow", 16'h0002);
        fire(3'd5, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, MFULL, 0);
        chk("R9 mulu top bit", 16'h000A);
    endtask

    task automatic t_btst;
        fire(3'd0, 2'd0, 32'h80, 32'h80, 32'h100, 0, MFULL, 0);
        fire(3'd6, 2'd2, 32'd4, 32'h10, 0, 0, 16'h0000, 0);
        chk("R10 btst bit set", 16'h0008);
        fire(3'd6, 2'd2, 32'd5, 32'h10, 0, 0, MFULL, 0);
        chk("R10 btst lower nonzero", 16'h0000);
        fire(3'd6, 2'd2, 32'd31, 32'h8000_0000, 0, 0, MFULL, 0);
        chk("R10 btst top bit", 16'h0008);
        fire(3'd3, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, MFULL, 0);
        fire(3'd6, 2'd2, 32'd3, 32'h10, 0, 0, MFULL, 0);
        chk("R10 btst keeps R", 16'h0104);
    endtask

    task automatic t_hold;
        fire(3'd7, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, MFULL, 0);
        chk("R13 hold class", 16'h0104);
        @(negedge clk);
        op_i = 3'd0; res_i = 32'h8000_0000; upd_mask_i = MFULL;
        repeat (3) @(negedge clk);
        chk("R2 no strobe", 16'h0104);
    endtask

    initial begin
        t_reset;
        t_add;
        t_sub;
        t_move;
        t_mask_x;
        t_mcp;
        t_mul;
        t_btst;
        t_hold;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule